// File: doc/BRIEF.md
# Trigger Output Router with Edge-to-Pulse Conversion

This block produces one output line of a trigger matrix. A 7-bit index picks one line from a wide bus of trigger inputs. The picked line can pass through as a level, or it can be turned into single-cycle pulses on its rising edges, its falling edges or both. The result can then be inverted. Last, one bit of a shared enable vector gates the line, and the line is registered onto the output pin.

Several copies of the block sit side by side in a trigger matrix. Each copy has its own select, edge and invert controls, and its own position in the shared enable vector. The edge detector compares the picked line with its value from one clock earlier. Whenever the select changes, that history is reloaded, so switching sources never produces a false edge.

Top module: `trig_route_out`

## Requirements
- R1: `src_sel` picks `trig_bus[src_sel]` as the source. Any index of `NUM_IN` or above gives a constant 0 source.
- R2: With only `rise_pulse_en` set, a 0-to-1 change of the source gives a pulse exactly one clock wide, and nothing else gives a pulse.
- R3: With only `fall_pulse_en` set, a 1-to-0 change of the source gives a pulse exactly one clock wide, and nothing else gives a pulse.
- R4: With both edge enables set, either kind of change gives a one-clock pulse. With neither set, the source level passes through unchanged.
- R5: `out_inv` = 1 inverts the result of the edge stage. Under inversion a pulse therefore appears as a one-clock low.
- R6: The output is driven only while `out_en_vec[OUT_IDX]` is 1. Otherwise it is 0, whatever the invert setting.
- R7: In a cycle where `src_sel` differs from its value on the previous clock, no edge is reported.
- R8: `trig_out` is registered. It reflects the inputs present at the previous rising clock edge. While `rst_n` is low, `trig_out` is 0 and the history tracks the current source, so no edge is reported on the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_bus | input | NUM_IN | Trigger input bus |
| src_sel | input | SEL_W | Source index |
| rise_pulse_en | input | 1 | Convert rising edges to pulses |
| fall_pulse_en | input | 1 | Convert falling edges to pulses |
| out_inv | input | 1 | Invert after edge conversion |
| out_en_vec | input | EN_W | Shared output enable vector; bit OUT_IDX gates this output |
| trig_out | output | 1 | Registered trigger output |

## Verification
The hardest case to reach from the ports is a select change in the same cycle as a level difference between the old source and the new one. Random buses make such differences common, but the select must also move on exactly that cycle. The stimulus therefore changes the select on roughly one cycle in eight while every bus bit is redrawn each cycle. A directed sequence also switches between a high line and a low line while edge conversion is on, and separate directed runs measure the width of rising, falling and inverted pulses.

// File: rtl/trig_route_pkg.sv
`timescale 1ns/1ps
// Shared types for the trigger output router.
// Assumes the two edge-enable bits are decoded into one mode value.
package trig_route_pkg;

    typedef enum logic [1:0] {
        EM_LEVEL = 2'b00,
        EM_RISE  = 2'b01,
        EM_FALL  = 2'b10,
        EM_BOTH  = 2'b11
    } edge_mode_e;

    // Decode the two enable bits into a mode.
    function automatic edge_mode_e mode_of(input logic rise, input logic fall);
        return edge_mode_e'({fall, rise});
    endfunction

endpackage

// File: rtl/trig_src_mux.sv
`timescale 1ns/1ps
// Source selector: picks one bus line by index.
// Assumes NUM_IN <= 2**SEL_W. Unimplemented indices read as 0.
module trig_src_mux #(
    parameter int NUM_IN = 68,
    parameter int SEL_W  = 7
) (
    input  logic [NUM_IN-1:0] bus,
    input  logic [SEL_W-1:0]  sel,
    output logic              lvl
);
    localparam int SPAN = 2 ** SEL_W;

    logic [SPAN-1:0] padded;

    // Widen the bus to the full index span; unused slots tie low.
    for (genvar i = 0; i < SPAN; i++) begin : g_pad
        if (i < NUM_IN) begin : g_real
            assign padded[i] = bus[i];
        end else begin : g_zero
            assign padded[i] = 1'b0;
        end
    end

    // Index into the widened vector.
    always_comb lvl = padded[sel];

endmodule

// File: rtl/trig_edge_pulse.sv
`timescale 1ns/1ps
// Edge-to-pulse stage: compares the source with its previous-cycle value.
// Assumes the history is reloaded whenever the select moves, which
// suppresses any edge in the cycle of the switch. The history always
// tracks the source, so reset needs no special value here.
module trig_edge_pulse
    import trig_route_pkg::*;
#(
    parameter int SEL_W = 7
) (
    input  logic             clk,
    input  logic             src_lvl,
    input  logic [SEL_W-1:0] src_sel,
    input  edge_mode_e       mode,
    output logic             edge_lvl
);
    logic             prev_q;
    logic [SEL_W-1:0] sel_q;
    logic             prev_eff;
    logic             rise_hit;
    logic             fall_hit;

    // Record the source level and the select for the next cycle.
    always_ff @(posedge clk) begin
        prev_q <= src_lvl;
        sel_q  <= src_sel;
    end

    // Mask the history while the select differs from last cycle.
    always_comb prev_eff = (src_sel != sel_q) ? src_lvl : prev_q;

    // Detect both edge kinds.
    always_comb begin
        rise_hit = src_lvl & ~prev_eff;
        fall_hit = ~src_lvl & prev_eff;
    end

    // Choose level or pulse form according to the mode.
    always_comb begin
        unique case (mode)
            EM_LEVEL: edge_lvl = src_lvl;
            EM_RISE:  edge_lvl = rise_hit;
            EM_FALL:  edge_lvl = fall_hit;
            EM_BOTH:  edge_lvl = rise_hit | fall_hit;
            default:  edge_lvl = 1'b0;
        endcase
    end

endmodule

// File: rtl/trig_out_stage.sv
`timescale 1ns/1ps
// Output stage: invert, gate with the enable, register.
// Assumes a disabled output must read 0 regardless of the invert setting.
module trig_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic inv,
    input  logic en,
    output logic q
);
    // Register the inverted, gated level; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= en & (lvl ^ inv);
    end

endmodule

// File: rtl/trig_route_out.sv
`timescale 1ns/1ps
// Trigger output router top: select -> edge stage -> invert -> enable gate.
// Assumes OUT_IDX < EN_W and NUM_IN <= 2**SEL_W. One clock of latency.
module trig_route_out
    import trig_route_pkg::*;
#(
    parameter int NUM_IN  = 68,
    parameter int SEL_W   = 7,
    parameter int EN_W    = 12,
    parameter int OUT_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] trig_bus,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic              rise_pulse_en,
    input  logic              fall_pulse_en,
    input  logic              out_inv,
    input  logic [EN_W-1:0]   out_en_vec,
    output logic              trig_out
);
    logic       src_lvl;
    logic       edge_lvl;
    edge_mode_e mode;

    // Decode the edge enables.
    always_comb mode = mode_of(rise_pulse_en, fall_pulse_en);

    trig_src_mux #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) u_mux (
        .bus (trig_bus),
        .sel (src_sel),
        .lvl (src_lvl)
    );

    trig_edge_pulse #(.SEL_W(SEL_W)) u_edge (
        .clk      (clk),
        .src_lvl  (src_lvl),
        .src_sel  (src_sel),
        .mode     (mode),
        .edge_lvl (edge_lvl)
    );

    trig_out_stage u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (edge_lvl),
        .inv   (out_inv),
        .en    (out_en_vec[OUT_IDX]),
        .q     (trig_out)
    );

endmodule

// File: rtl/trig_route_chk.sv
`timescale 1ns/1ps
// Assertion checker for trig_route_out, attached with bind below.
// Assumes it sees the mux output and the edge-stage output of the top.
module trig_route_chk #(
    parameter int NUM_IN  = 68,
    parameter int SEL_W   = 7,
    parameter int EN_W    = 12,
    parameter int OUT_IDX = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  src_sel,
    input logic              rise_pulse_en,
    input logic              fall_pulse_en,
    input logic              out_inv,
    input logic [EN_W-1:0]   out_en_vec,
    input logic              trig_out,
    input logic              src_lvl,
    input logic              edge_lvl
);
    localparam logic [SEL_W:0] LIMIT = NUM_IN[SEL_W:0];

    // R1: indices past the bus read as 0
    a_r1_high_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, src_sel} >= LIMIT) |-> !src_lvl);

    // R2: single-edge rising pulses never last two cycles
    a_r2_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_pulse_en && !fall_pulse_en && edge_lvl)
        |=> !(rise_pulse_en && !fall_pulse_en && edge_lvl));

    // R3: single-edge falling pulses never last two cycles
    a_r3_fall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_pulse_en && !rise_pulse_en && edge_lvl)
        |=> !(fall_pulse_en && !rise_pulse_en && edge_lvl));

    // R4 and R5: level mode passes the source, possibly inverted, one clock later
    a_r4_level_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_pulse_en && !fall_pulse_en && out_en_vec[OUT_IDX])
        |=> (trig_out == ($past(src_lvl) ^ $past(out_inv))));

    // R6: a disabled output reads 0 on the next cycle
    a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_vec[OUT_IDX] |=> !trig_out);

    // R7: no edge in the cycle the select moves
    a_r7_switch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_pulse_en || fall_pulse_en) && (src_sel != $past(src_sel)))
        |-> !edge_lvl);

endmodule

bind trig_route_out trig_route_chk #(
    .NUM_IN(NUM_IN), .SEL_W(SEL_W), .EN_W(EN_W), .OUT_IDX(OUT_IDX)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_sel       (src_sel),
    .rise_pulse_en (rise_pulse_en),
    .fall_pulse_en (fall_pulse_en),
    .out_inv       (out_inv),
    .out_en_vec    (out_en_vec),
    .trig_out      (trig_out),
    .src_lvl       (src_lvl),
    .edge_lvl      (edge_lvl)
);

// File: tb/sim_trig_route_out.sv
`timescale 1ns/1ps
// Bench for trig_route_out: seeded random sweeps plus directed pulse-width runs.
module sim_trig_route_out;
    localparam int NUM_IN  = 68;
    localparam int SEL_W   = 7;
    localparam int EN_W    = 12;
    localparam int OUT_IDX = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_IN-1:0] trig_bus = '0;
    logic [SEL_W-1:0]  src_sel = '0;
    logic              rise_pulse_en = 1'b0;
    logic              fall_pulse_en = 1'b0;
    logic              out_inv = 1'b0;
    logic [EN_W-1:0]   out_en_vec = '0;
    logic              trig_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic m_prev = 1'b0;
    logic [SEL_W-1:0] m_sel = '0;
    logic done = 1'b0;
    int unsigned seed_v;

    always #2 clk = ~clk;

    trig_route_out #(.NUM_IN(NUM_IN), .SEL_W(SEL_W), .EN_W(EN_W), .OUT_IDX(OUT_IDX)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_bus(trig_bus), .src_sel(src_sel),
        .rise_pulse_en(rise_pulse_en), .fall_pulse_en(fall_pulse_en),
        .out_inv(out_inv), .out_en_vec(out_en_vec), .trig_out(trig_out)
    );

    function automatic logic src_of(logic [NUM_IN-1:0] b, logic [SEL_W-1:0] s);
        return (int'(s) < NUM_IN) ? b[s] : 1'b0;
    endfunction

    function automatic logic expect_out(logic cur, logic prev, logic sw,
                                        logic r, logic f, logic inv, logic en);
        logic p, lv;
        p = sw ? cur : prev;
        if (r || f) lv = (r & cur & ~p) | (f & ~cur & p);
        else        lv = cur;
        return en & (lv ^ inv);
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: trig_out=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: inputs already driven; compute, wait, compare, advance the model.
    task automatic step(output logic got);
        logic cur, sw, exp;
        string tag;
        cur = src_of(trig_bus, src_sel);
        sw  = (src_sel != m_sel);
        if (!rst_n) begin exp = 1'b0; tag = "R8"; end
        else begin
            exp = expect_out(cur, m_prev, sw, rise_pulse_en, fall_pulse_en,
                             out_inv, out_en_vec[OUT_IDX]);
            if (!out_en_vec[OUT_IDX])            tag = "R6";
            else if (int'(src_sel) >= NUM_IN)    tag = "R1";
            else if (sw && (rise_pulse_en || fall_pulse_en)) tag = "R7";
            else if (out_inv)                    tag = "R5";
            else if (rise_pulse_en == fall_pulse_en) tag = "R4";
            else if (rise_pulse_en)              tag = "R2";
            else                                 tag = "R3";
        end
        @(posedge clk);
        #1;
        check(trig_out, exp, tag);
        got = trig_out;
        m_prev = cur;
        m_sel  = src_sel;
        @(negedge clk);
    endtask

    // Directed pulse-width run: hold level, flip selected line once, count active cycles.
    task automatic width_run(input logic r, input logic f, input logic inv,
                             input logic start, input string tag);
        logic g;
        int act;
        act = 0;
        src_sel = 7'd10; rise_pulse_en = r; fall_pulse_en = f; out_inv = inv;
        out_en_vec = '0; out_en_vec[OUT_IDX] = 1'b1;
        trig_bus = '0; trig_bus[10] = start;
        for (int k = 0; k < 3; k++) step(g);
        trig_bus[10] = ~start;
        for (int k = 0; k < 6; k++) begin
            step(g);
            if (g != inv) act++;
        end
        n_cmp++;
        if (act != 1) begin
            n_bad++;
            $display("FAIL %s: pulse width=%0d expected=1", tag, act);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic g;
        seed_v = $urandom(32'h5eed_2024);
        @(negedge clk);
        // R8: output low and history loaded during reset
        src_sel = 7'd3; trig_bus = '1;
        rise_pulse_en = 1'b1; out_en_vec = '1;
        for (int k = 0; k < 4; k++) step(g);
        rst_n = 1'b1;
        step(g);   // R8: no edge on first cycle after reset

        width_run(1'b1, 1'b0, 1'b0, 1'b0, "R2");
        width_run(1'b0, 1'b1, 1'b0, 1'b1, "R3");
        width_run(1'b1, 1'b1, 1'b0, 1'b1, "R4");
        width_run(1'b1, 1'b0, 1'b1, 1'b0, "R5");

        // R7: switch from a low line to a high line under edge mode
        trig_bus = '0; trig_bus[20] = 1'b1; src_sel = 7'd21;
        rise_pulse_en = 1'b1; fall_pulse_en = 1'b1; out_inv = 1'b0;
        step(g); step(g);
        src_sel = 7'd20; step(g);
        src_sel = 7'd21; step(g);

        // R1: out-of-range index in level mode with invert
        rise_pulse_en = 1'b0; fall_pulse_en = 1'b0; out_inv = 1'b1;
        trig_bus = '1; src_sel = 7'd127; step(g); step(g);
        src_sel = 7'd67; step(g);

        // R6: disabled output with invert set
        out_en_vec = '1; out_en_vec[OUT_IDX] = 1'b0; step(g);

        // Random sweep over selects, modes, invert and enables.
        for (int n = 0; n < 4000; n++) begin
            for (int w = 0; w < NUM_IN; w += 32) begin
                logic [31:0] rv;
                rv = $urandom;
                for (int b = 0; b < 32; b++)
                    if (w + b < NUM_IN) trig_bus[w + b] = rv[b];
            end
            if ($urandom_range(7) == 0) src_sel = SEL_W'($urandom_range(127));
            if ($urandom_range(31) == 0) begin
                rise_pulse_en = 1'($urandom);
                fall_pulse_en = 1'($urandom);
                out_inv       = 1'($urandom);
            end
            out_en_vec = EN_W'($urandom);
            if ($urandom_range(3) != 0) out_en_vec[OUT_IDX] = 1'b1;
            step(g);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule